// File: doc/BRIEF.md
# Harmonic Cancellation Channel for a Direct Digital Synthesizer

This block produces a small sinusoid at an integer multiple of a synthesizer's output frequency. The caller sets its phase and amplitude so that, once added to the primary sample in front of the DAC, it cancels a harmonic spur that the converter creates. The channel has no phase accumulator. Each cycle it takes the primary accumulator's phase word, multiplies it by a harmonic number with modulo arithmetic, and truncates the product to a short table index. It then adds a phase offset, looks up a low-resolution signed sine, and scales that value by an amplitude code.

The sine table is sized for spur-level amplitudes: 6 amplitude bits addressed by 9 phase bits. The phase input is therefore 3 bits wider than the amplitude. The harmonic number, offset and scale travel down the pipeline together with the phase word they were presented with. A change of setting therefore applies from exactly the sample it accompanies.

Top module: `hcd_channel`

## Requirements
- R1: While reset is asserted, and until the first valid sample leaves the pipeline, `out_valid` is 0 and `out_sample` is 0.
- R2: A sample presented with `in_valid`=1 at a rising edge appears on `out_valid`/`out_sample` after the third rising edge that follows, a fixed latency of 4 register stages. `out_valid` is otherwise 0.
- R3: The table index is the top Q_W (9) bits of (in_phase × harm_num) mod 2^PHASE_W, plus the offset. Harmonic numbers wrap naturally in the phase word.
- R4: `phase_ofs` is added to the index modulo 2^Q_W. An offset of 256 (half a turn) negates the looked-up sine.
- R5: The table entry for index k is round(31·sin(2πk/512)), with halves rounded away from zero, as a two's-complement 6-bit value.
- R6: `out_sample` = floor((sine × amp_scale + 128) / 256), where `amp_scale` is unsigned. A scale of 0 gives 0.
- R7: `out_sample` always lies within −31..+31.
- R8: A harmonic number of 0 or 1 mutes the sample (output 0 while `out_valid` is still 1).
- R9: The harmonic number, offset and scale are captured together with each valid phase word. Back-to-back samples with different settings each use their own settings.
- R10: When `out_valid` is 0, `out_sample` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Phase word and settings are valid this cycle |
| in_phase | input | 32 | Primary accumulator phase word |
| harm_num | input | 4 | Integer harmonic number (2..15 active) |
| phase_ofs | input | 9 | Phase offset in table steps |
| amp_scale | input | 8 | Unsigned amplitude gain, value/256 |
| out_valid | output | 1 | Cancellation sample valid |
| out_sample | output | 6 | Signed cancellation sample |

## Verification
The bench uses the default parameters: a 32-bit phase word, a 4-bit harmonic number, a 9-bit index and a 6-bit amplitude. With these, products of a phase word near full turn and harmonics up to 15 overflow the word, so the modulo wrap is exercised. Offsets that push the index past 511 are reachable, and so are the exact table peaks, where rounding of the scaled product meets the ±31 range bound. Streams that change settings on every cycle show that each setting stays paired with its own phase word.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

  localparam real HCD_TWO_PI = 6.283185307179586;

  // Rounded signed sine entry for a table of 2^qw points, peak 2^(sw-1)-1
  function automatic int sine_entry(input int idx, input int qw, input int sw);
    real peak;
    real r;
    int  v;
    begin
      peak = real'((1 << (sw - 1)) - 1);
      r    = peak * $sin(HCD_TWO_PI * real'(idx) / real'(1 << qw));
      if (r >= 0.0) v = int'($floor(r + 0.5));
      else          v = -int'($floor(-r + 0.5));
      return v;
    end
  endfunction

endpackage

// File: rtl/hcd_phase_mult.sv
module hcd_phase_mult #(
  parameter int PHASE_W = 32,
  parameter int HARM_W  = 4,
  parameter int Q_W     = 9,
  parameter int SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               v_in,
  input  logic [PHASE_W-1:0] phase_in,
  input  logic [HARM_W-1:0]  harm_in,
  input  logic [Q_W-1:0]     ofs_in,
  input  logic [SCALE_W-1:0] scale_in,
  input  logic               mute_in,
  output logic               v_out,
  output logic [Q_W-1:0]     addr_out,
  output logic [SCALE_W-1:0] scale_out,
  output logic               mute_out
);

  localparam int PROD_W = PHASE_W + HARM_W;

  logic [PROD_W-1:0]  prod_full;
  logic [PHASE_W-1:0] prod_wrap;
  logic [Q_W-1:0]     addr_nxt;

  always_comb begin
    prod_full = PROD_W'(phase_in) * PROD_W'(harm_in);
    prod_wrap = prod_full[PHASE_W-1:0];
    addr_nxt  = prod_wrap[PHASE_W-1 -: Q_W] + ofs_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out     <= 1'b0;
      addr_out  <= '0;
      scale_out <= '0;
      mute_out  <= 1'b0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        addr_out  <= addr_nxt;
        scale_out <= scale_in;
        mute_out  <= mute_in;
      end
    end
  end

  // R4: a half-turn offset on the same phase moves the index by exactly half the table
  AST_OFS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && $past(v_in) && $stable(phase_in) && $stable(harm_in) &&
     (ofs_in == $past(ofs_in) + Q_W'(1 << (Q_W - 1))))
    |=> (addr_out == $past(addr_out) + Q_W'(1 << (Q_W - 1)))); // R4

endmodule

// File: rtl/hcd_sine_rom.sv
module hcd_sine_rom #(
  parameter int Q_W     = 9,
  parameter int AMP_W   = 6,
  parameter int SCALE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_in,
  input  logic [Q_W-1:0]          addr_in,
  input  logic [SCALE_W-1:0]      scale_in,
  input  logic                    mute_in,
  output logic                    v_out,
  output logic signed [AMP_W-1:0] sine_out,
  output logic [SCALE_W-1:0]      scale_out,
  output logic                    mute_out
);

  localparam int DEPTH = 1 << Q_W;
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

  logic signed [AMP_W-1:0] table_w [DEPTH];
  logic signed [AMP_W-1:0] sine_nxt;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tab
    localparam int ENTRY = hcd_pkg::sine_entry(gi, Q_W, AMP_W);
    assign table_w[gi] = AMP_W'(ENTRY);
  end

  always_comb sine_nxt = table_w[addr_in];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out     <= 1'b0;
      sine_out  <= '0;
      scale_out <= '0;
      mute_out  <= 1'b0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        sine_out  <= sine_nxt;
        scale_out <= scale_in;
        mute_out  <= mute_in;
      end
    end
  end

  // R7: the table never produces the most negative code
  AST_TAB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    v_out |-> (sine_out >= -AMP_W'(PEAK)) && (sine_out <= AMP_W'(PEAK))); // R7

endmodule

// File: rtl/hcd_amp_scale.sv
module hcd_amp_scale #(
  parameter int AMP_W   = 6,
  parameter int SCALE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    v_in,
  input  logic signed [AMP_W-1:0] sine_in,
  input  logic [SCALE_W-1:0]      scale_in,
  input  logic                    mute_in,
  output logic                    v_out,
  output logic signed [AMP_W-1:0] sample_out
);

  localparam int MUL_W = AMP_W + SCALE_W + 1;
  localparam int PEAK  = (1 << (AMP_W - 1)) - 1;

  logic signed [MUL_W-1:0] prod;
  logic signed [MUL_W-1:0] prod_rnd;
  logic signed [AMP_W-1:0] sample_nxt;

  always_comb begin
    prod       = MUL_W'(sine_in) * $signed({1'b0, scale_in});
    prod_rnd   = prod + MUL_W'(1 << (SCALE_W - 1));
    sample_nxt = AMP_W'(prod_rnd >>> SCALE_W);
    if (!v_in || mute_in) sample_nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_out      <= 1'b0;
      sample_out <= '0;
    end else begin
      v_out      <= v_in;
      sample_out <= sample_nxt;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_out >= -AMP_W'(PEAK)) && (sample_out <= AMP_W'(PEAK))); // R7

  AST_ZERO_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && scale_in == '0) |=> (sample_out == '0)); // R6

  AST_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (v_in && mute_in) |=> (v_out && sample_out == '0)); // R8

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !v_out |-> (sample_out == '0)); // R10

endmodule

// File: rtl/hcd_channel.sv
module hcd_channel #(
  parameter int PHASE_W = 32,
  parameter int HARM_W  = 4,
  parameter int Q_W     = 9,
  parameter int AMP_W   = 6,
  parameter int SCALE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [PHASE_W-1:0]      in_phase,
  input  logic [HARM_W-1:0]       harm_num,
  input  logic [Q_W-1:0]          phase_ofs,
  input  logic [SCALE_W-1:0]      amp_scale,
  output logic                    out_valid,
  output logic signed [AMP_W-1:0] out_sample
);

  localparam int LATENCY = 4;
  localparam int CNT_W   = $clog2(LATENCY + 1);

  // reset synchronizer: assert asynchronously, release on clock
  logic rst_meta, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  // stage 1: capture phase with its settings
  logic               s1_v;
  logic [PHASE_W-1:0] s1_phase;
  logic [HARM_W-1:0]  s1_harm;
  logic [Q_W-1:0]     s1_ofs;
  logic [SCALE_W-1:0] s1_scale;
  logic               s1_mute;
  logic               mute_nxt;

  always_comb mute_nxt = (harm_num < HARM_W'(2));

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      s1_v     <= 1'b0;
      s1_phase <= '0;
      s1_harm  <= '0;
      s1_ofs   <= '0;
      s1_scale <= '0;
      s1_mute  <= 1'b0;
    end else begin
      s1_v <= in_valid;
      if (in_valid) begin
        s1_phase <= in_phase;
        s1_harm  <= harm_num;
        s1_ofs   <= phase_ofs;
        s1_scale <= amp_scale;
        s1_mute  <= mute_nxt;
      end
    end
  end

  logic               s2_v, s2_mute;
  logic [Q_W-1:0]     s2_addr;
  logic [SCALE_W-1:0] s2_scale;

  hcd_phase_mult #(
    .PHASE_W(PHASE_W), .HARM_W(HARM_W), .Q_W(Q_W), .SCALE_W(SCALE_W)
  ) u_pmul (
    .clk(clk), .rst_n(rst_sn),
    .v_in(s1_v), .phase_in(s1_phase), .harm_in(s1_harm), .ofs_in(s1_ofs),
    .scale_in(s1_scale), .mute_in(s1_mute),
    .v_out(s2_v), .addr_out(s2_addr), .scale_out(s2_scale), .mute_out(s2_mute)
  );

  logic                    s3_v, s3_mute;
  logic signed [AMP_W-1:0] s3_sine;
  logic [SCALE_W-1:0]      s3_scale;

  hcd_sine_rom #(
    .Q_W(Q_W), .AMP_W(AMP_W), .SCALE_W(SCALE_W)
  ) u_rom (
    .clk(clk), .rst_n(rst_sn),
    .v_in(s2_v), .addr_in(s2_addr), .scale_in(s2_scale), .mute_in(s2_mute),
    .v_out(s3_v), .sine_out(s3_sine), .scale_out(s3_scale), .mute_out(s3_mute)
  );

  hcd_amp_scale #(
    .AMP_W(AMP_W), .SCALE_W(SCALE_W)
  ) u_amp (
    .clk(clk), .rst_n(rst_sn),
    .v_in(s3_v), .sine_in(s3_sine), .scale_in(s3_scale), .mute_in(s3_mute),
    .v_out(out_valid), .sample_out(out_sample)
  );

  // cycles since reset release, saturating, used to bound the latency check
  logic [CNT_W-1:0] since_rst;
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)                         since_rst <= '0;
    else if (since_rst != CNT_W'(LATENCY)) since_rst <= since_rst + CNT_W'(1);
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_sn)
    (since_rst == CNT_W'(LATENCY)) |-> (out_valid == $past(in_valid, 4))); // R2

  AST_EARLY_QUIET: assert property (@(posedge clk) disable iff (!rst_sn)
    (since_rst < CNT_W'(LATENCY - 1)) |-> !out_valid); // R1

endmodule

// File: tb/hcd_channel_tb.sv
module hcd_channel_tb;

  localparam int PW = 32;
  localparam int HW = 4;
  localparam int QW = 9;
  localparam int AW = 6;
  localparam int SW = 8;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 in_valid;
  logic [PW-1:0]        in_phase;
  logic [HW-1:0]        harm_num;
  logic [QW-1:0]        phase_ofs;
  logic [SW-1:0]        amp_scale;
  logic                 out_valid;
  logic signed [AW-1:0] out_sample;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  hcd_channel u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .harm_num(harm_num), .phase_ofs(phase_ofs), .amp_scale(amp_scale),
    .out_valid(out_valid), .out_sample(out_sample)
  );

  // expected sample from the requirements
  function automatic int tab_val(input int k);
    real r;
    r = 31.0 * $sin(6.283185307179586 * real'(k) / 512.0);
    if (r >= 0.0) return int'($floor(r + 0.5));
    return -int'($floor(-r + 0.5));
  endfunction

  function automatic int model(input logic [31:0] ph, input int h, input int ofs, input int sc);
    longint unsigned p;
    int idx, s;
    if (h < 2) return 0;                          // R8
    p   = (longint'(ph) * longint'(h)) & 64'hFFFF_FFFF; // R3
    idx = (int'(p >> 23) + ofs) & 511;            // R4
    s   = tab_val(idx);                           // R5
    return (s * sc + 128) >>> 8;                  // R6
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one isolated sample, latency checked cycle by cycle
  task automatic single(input string req, input logic [31:0] ph, input int h,
                        input int ofs, input int sc);
    int exp;
    exp = model(ph, h, ofs, sc);
    @(negedge clk);
    in_valid = 1'b1; in_phase = ph; harm_num = HW'(h);
    phase_ofs = QW'(ofs); amp_scale = SW'(sc);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 early valid", int'(out_valid), 0);
    check("R10 idle zero", int'(out_sample), 0);
    @(negedge clk);
    check("R2 valid at latency", int'(out_valid), 1);
    check(req, int'(out_sample), exp);
    @(negedge clk);
    check("R2 single pulse", int'(out_valid), 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_phase = '0; harm_num = '0;
    phase_ofs = '0; amp_scale = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", int'(out_valid), 0);
    check("R1 sample in reset", int'(out_sample), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid after reset", int'(out_valid), 0);
    check("R1 sample after reset", int'(out_sample), 0);
  endtask

  task automatic t_corners;
    single("R5 zero phase", 32'h0, 2, 0, 255);
    single("R5 R6 positive peak", 32'h2000_0000, 2, 0, 255);
    single("R4 R7 half-turn negative peak", 32'h2000_0000, 2, 256, 255);
    single("R6 zero scale", 32'h2000_0000, 2, 0, 0);
    single("R6 half scale", 32'h2000_0000, 2, 0, 128);
    single("R3 wrap third harmonic", 32'hC000_0000, 3, 0, 255);
    single("R3 fifteenth harmonic", 32'hFFFF_FFFF, 15, 0, 200);
    single("R4 offset wraps index", 32'h7D00_0000, 2, 20, 255);
    single("R8 harmonic one muted", 32'h2000_0000, 1, 0, 255);
    single("R8 harmonic zero muted", 32'h4000_0000, 0, 0, 255);
    single("R5 R6 odd index", 32'h0123_4567, 7, 33, 91);
  endtask

  // back-to-back samples, each with its own settings
  task automatic t_stream;
    logic [31:0] ph [16];
    int hh [16], oo [16], ss [16], ee [16];
    for (int i = 0; i < 16; i++) begin
      ph[i] = 32'h1357_9BDF * (i + 1) + 32'h0F0F_0000 * i;
      hh[i] = (i * 5 + 2) % 16;
      oo[i] = (i * 37) % 512;
      ss[i] = (i * 67 + 13) % 256;
      ee[i] = model(ph[i], hh[i], oo[i], ss[i]);
    end
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (c >= 4) begin
        check("R9 stream valid", int'(out_valid), 1);
        check("R9 stream sample", int'(out_sample), ee[c-4]);
        check("R7 stream range",
              int'(out_sample >= -31 && out_sample <= 31), 1);
      end
      if (c < 16) begin
        in_valid = 1'b1; in_phase = ph[c]; harm_num = HW'(hh[c]);
        phase_ofs = QW'(oo[c]); amp_scale = SW'(ss[c]);
      end else begin
        in_valid = 1'b0;
      end
    end
    @(negedge clk);
    check("R10 stream drained", int'(out_valid) + int'(out_sample), 0);
  endtask

  // sweep all table indices at full scale (harmonic 2, phase selects index)
  task automatic t_sweep;
    for (int k = 0; k < 512; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_phase = 32'(k) << 22; harm_num = 4'd2;
      phase_ofs = '0; amp_scale = 8'd255;
      if (k >= 4)
        check("R5 table sweep", int'(out_sample), model(32'(k - 4) << 22, 2, 0, 255));
    end
    @(negedge clk); in_valid = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_corners();
    t_stream();
    t_sweep();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule